// File: doc/BRIEF.md
# Sequential Matrix-Vector Product Core

This core multiplies a square unsigned matrix by a vector of the same order. Every operand is presented on a wide parallel input. The default size is five by five, with 15-bit elements. A single multiply-accumulate datapath is shared across all terms. It handles one product per clock and walks the columns of one row before it moves to the next row.

All arithmetic is unsigned and wraps modulo 2^W. This applies to each product and to the running sum.

A host that sees `idle_o` high presents the operands and raises `start_i`. The host must hold the operands steady until `done_o` arrives. Each result word is written as soon as its row completes, and a one-cycle strobe marks the write. After the last row, `done_o` and `ready_o` pulse together and the core goes back to idle. Result words stay on their outputs until a later run rewrites them.

Top module: `mvm_core`

## Requirements
- R1: Result i, at `res_o[i*W +: W]`, equals the sum over j of A[i][j]*b[j] modulo 2^W. Element A[i][j] is read from `mat_i[(i*DIM+j)*W +: W]` and element b[j] from `vec_i[j*W +: W]`.
- R2: With rows {82,10,16,15,66}, {91,28,98,43,4}, {13,55,96,92,85}, {92,96,49,80,94}, {64,97,81,96,68} and vector {76,75,40,66,18}, the results are 9800, 15846, 16555, 23124 and 22939.
- R3: When every operand is 32767, each result is (5*32767*32767) mod 32768, which is 5.
- R4: The running sum restarts from zero at every row and at every run, so no result depends on an earlier row or an earlier run.
- R5: `idle_o` is high after reset and whenever no computation is in progress. It is low from the cycle after `start_i` is accepted until the done cycle, including the done cycle.
- R6: `start_i` is sampled only while `idle_o` is high. A start raised during a run or in the done cycle has no effect.
- R7: `done_o` and `ready_o` are high together for exactly one cycle. That cycle follows the DIM*DIM-th clock edge after the edge that accepted `start_i`. In the next cycle the core is idle.
- R8: `res_vld_o[i]` pulses for exactly one cycle, in the cycle after the DIM*(i+1)-th edge that follows the accepting edge. The strobes therefore fire in row order, at most one at a time, and the last one coincides with `done_o`.
- R9: A result word changes only in the cycle where its own strobe is high. While idle, changes on `mat_i` or `vec_i` leave `res_o` unchanged and raise no strobe.
- R10: While `rst_ni` is low, `idle_o` is 1, `done_o`, `ready_o` and `res_vld_o` are 0, and every result word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation (sampled only while idle) |
| mat_i | input | DIM*DIM*W | Matrix elements, row-major, element k at bits k*W |
| vec_i | input | DIM*W | Vector elements, element j at bits j*W |
| idle_o | output | 1 | No computation in progress |
| done_o | output | 1 | One-cycle pulse when all results are written |
| ready_o | output | 1 | One-cycle pulse, core can accept new operands |
| res_o | output | DIM*W | Result words, word i at bits i*W |
| res_vld_o | output | DIM | Per-result write strobe |

## Verification
The hardest case to reach from the ports is a start request that arrives while the core is busy. This matters most in the done cycle, where a core that sampled start one state too early would restart without ever reporting idle. The stimulus holds `start_i` high in the middle of a run and again exactly in the done cycle. It then requires that the single done pulse lands at its nominal cycle and that `idle_o` comes back high and stays high. The wrap case with every operand at its maximum tests modular arithmetic in both the product and the sum. A run with a saturated row followed by a zero row shows that the accumulator clears between rows.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } mvm_state_e;
endpackage

// File: rtl/mvm_ctrl.sv
module mvm_ctrl #(
  parameter int DIM = 5,
  localparam int IW = $clog2(DIM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [IW-1:0] row_o,
  output logic [IW-1:0] col_o,
  output logic          issue_o,
  output logic          first_o,
  output logic          last_o,
  output logic          idle_o,
  output logic          fin_o
);
  import mvm_pkg::*;

  mvm_state_e    state_q;
  logic [IW-1:0] row_q, col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          row_q   <= '0;
          col_q   <= '0;
        end
        ST_RUN: begin
          if (col_q == IW'(DIM - 1)) begin
            col_q <= '0;
            if (row_q == IW'(DIM - 1)) begin
              row_q   <= '0;
              state_q <= ST_FIN;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign row_o   = row_q;
  assign col_o   = col_q;
  assign issue_o = (state_q == ST_RUN);
  assign first_o = (col_q == '0);
  assign last_o  = (col_q == IW'(DIM - 1));
  assign idle_o  = (state_q == ST_IDLE);
  assign fin_o   = (state_q == ST_FIN);
endmodule

// File: rtl/mvm_mac.sv
module mvm_mac #(
  parameter int DIM = 5,
  parameter int W   = 15,
  localparam int IW   = $clog2(DIM),
  localparam int IDXW = $clog2(DIM * DIM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic               first_i,
  input  logic [IW-1:0]      row_i,
  input  logic [IW-1:0]      col_i,
  input  logic [DIM*DIM*W-1:0] mat_i,
  input  logic [DIM*W-1:0]   vec_i,
  output logic [W-1:0]       sum_o
);
  logic [W-1:0] a_arr [DIM*DIM];
  logic [W-1:0] b_arr [DIM];

  for (genvar k = 0; k < DIM * DIM; k++) begin : g_a
    assign a_arr[k] = mat_i[k*W +: W];
  end
  for (genvar k = 0; k < DIM; k++) begin : g_b
    assign b_arr[k] = vec_i[k*W +: W];
  end

  logic [IDXW-1:0] idx;
  logic [W-1:0]    prod, acc_q;

  // row-major flat index
  assign idx   = IDXW'(row_i) * IDXW'(DIM) + IDXW'(col_i);
  assign prod  = a_arr[idx] * b_arr[col_i];
  assign sum_o = (first_i ? '0 : acc_q) + prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (issue_i) acc_q <= sum_o;
  end
endmodule

// File: rtl/mvm_res.sv
module mvm_res #(
  parameter int DIM = 5,
  parameter int W   = 15,
  localparam int IW = $clog2(DIM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IW-1:0]    row_i,
  input  logic [W-1:0]     sum_i,
  output logic [DIM*W-1:0] res_o,
  output logic [DIM-1:0]   vld_o
);
  logic [DIM-1:0][W-1:0] res_q;
  logic [DIM-1:0]        vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= '0;
    end else begin
      for (int k = 0; k < DIM; k++) begin
        vld_q[k] <= 1'b0;
        if (wr_i && row_i == IW'(k)) begin
          res_q[k] <= sum_i;
          vld_q[k] <= 1'b1;
        end
      end
    end
  end

  assign res_o = res_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/mvm_core.sv
module mvm_core #(
  parameter int DIM = 5,
  parameter int W   = 15,
  localparam int IW = $clog2(DIM)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [DIM*DIM*W-1:0] mat_i,
  input  logic [DIM*W-1:0]     vec_i,
  output logic                 idle_o,
  output logic                 done_o,
  output logic                 ready_o,
  output logic [DIM*W-1:0]     res_o,
  output logic [DIM-1:0]       res_vld_o
);
  logic [IW-1:0] row, col;
  logic          issue, first, last, fin;
  logic [W-1:0]  sum;

  mvm_ctrl #(.DIM(DIM)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .row_o   (row),
    .col_o   (col),
    .issue_o (issue),
    .first_o (first),
    .last_o  (last),
    .idle_o  (idle_o),
    .fin_o   (fin)
  );

  mvm_mac #(.DIM(DIM), .W(W)) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .first_i (first),
    .row_i   (row),
    .col_i   (col),
    .mat_i   (mat_i),
    .vec_i   (vec_i),
    .sum_o   (sum)
  );

  mvm_res #(.DIM(DIM), .W(W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (issue && last),
    .row_i  (row),
    .sum_i  (sum),
    .res_o  (res_o),
    .vld_o  (res_vld_o)
  );

  assign done_o  = fin;
  assign ready_o = fin;
endmodule

// File: rtl/mvm_core_chk.sv
module mvm_core_chk #(
  parameter int DIM = 5,
  parameter int W   = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_o,
  input logic             done_o,
  input logic [DIM*W-1:0] res_o,
  input logic [DIM-1:0]   res_vld_o
);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> idle_o);
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!done_o && res_vld_o == '0));
  a_r6_busy_stays_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !done_o) |=> !idle_o);
  a_r8_vld_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(res_vld_o));
  a_r8_vld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o & $past(res_vld_o)) == '0);
  a_r8_last_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> res_vld_o[DIM-1]);

  for (genvar k = 0; k < DIM; k++) begin : g_hold
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(res_o[k*W +: W]) |-> res_vld_o[k]);
  end
endmodule

bind mvm_core mvm_core_chk #(.DIM(DIM), .W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .idle_o    (idle_o),
  .done_o    (done_o),
  .res_o     (res_o),
  .res_vld_o (res_vld_o)
);

// File: tb/mvm_core_bench.sv
module mvm_core_bench;
  localparam int DIM = 5;
  localparam int W   = 15;
  localparam int MW  = DIM * DIM * W;
  localparam int VW  = DIM * W;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [MW-1:0] mat_i = '0;
  logic [VW-1:0] vec_i = '0;
  logic          idle_o, done_o, ready_o;
  logic [VW-1:0] res_o;
  logic [DIM-1:0] res_vld_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mvm_core #(.DIM(DIM), .W(W)) u_mvm_core (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mat_i     (mat_i),
    .vec_i     (vec_i),
    .idle_o    (idle_o),
    .done_o    (done_o),
    .ready_o   (ready_o),
    .res_o     (res_o),
    .res_vld_o (res_vld_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_res(input logic [MW-1:0] m,
                                           input logic [VW-1:0] v, input int i);
    logic [W-1:0] s = '0;
    for (int j = 0; j < DIM; j++)
      s = s + W'(m[(i*DIM+j)*W +: W] * v[j*W +: W]);
    return s;
  endfunction

  function automatic logic [W-1:0] res_word(input int i);
    return res_o[i*W +: W];
  endfunction

  // start a run from idle (entered at a negedge) and check timing and results
  task automatic run_core(input logic [MW-1:0] m, input logic [VW-1:0] v,
                          input bit poke, input string req);
    int vld_at[DIM];
    int done_at = -1, done_cnt = 0, rdy_bad = 0, vld_cnt = 0;
    int idle_busy = 0, idle_late = 0;
    for (int k = 0; k < DIM; k++) vld_at[k] = -1;
    mat_i = m;
    vec_i = v;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < DIM; k++)
        if (res_vld_o[k]) begin
          vld_cnt++;
          if (vld_at[k] < 0) vld_at[k] = n;
        end
      if (done_o) begin
        done_cnt++;
        if (done_at < 0) done_at = n;
      end
      if (done_o != ready_o) rdy_bad++;
      if (n <= DIM * DIM && idle_o) idle_busy++;
      if (n > DIM * DIM && !idle_o) idle_late++;
      start_i = poke && (n == 5 || n == DIM * DIM);
      @(posedge clk);
      @(negedge clk);
    end
    start_i = 1'b0;
    for (int i = 0; i < DIM; i++)
      check(res_word(i) == ref_res(m, v, i), req, $sformatf("R1 result %0d", i),
            res_word(i), ref_res(m, v, i));
    for (int k = 0; k < DIM; k++)
      check(vld_at[k] == DIM * (k + 1), "R8", $sformatf("strobe %0d cycle", k),
            vld_at[k], DIM * (k + 1));
    check(vld_cnt == DIM, "R8", "strobe count", vld_cnt, DIM);
    check(done_at == DIM * DIM, poke ? "R6" : "R7", "done cycle", done_at, DIM * DIM);
    check(done_cnt == 1, poke ? "R6" : "R7", "done pulses", done_cnt, 1);
    check(rdy_bad == 0, "R7", "ready differs from done", rdy_bad, 0);
    check(idle_busy == 0, "R5", "idle high while busy", idle_busy, 0);
    check(idle_late == 0, poke ? "R6" : "R5", "idle low after done", idle_late, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(idle_o == 1'b1, "R10", "idle in reset", idle_o, 1);
    check(done_o == 1'b0 && ready_o == 1'b0, "R10", "done/ready in reset",
          {done_o, ready_o}, 0);
    check(res_vld_o == '0, "R10", "strobes in reset", res_vld_o, 0);
    check(res_o == '0, "R10", "results in reset", (res_o != '0), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(idle_o == 1'b1, "R5", "idle after reset", idle_o, 1);
  endtask

  task automatic t_wrap;
    logic [MW-1:0] m = '1;
    logic [VW-1:0] v = '1;
    run_core(m, v, 1'b0, "R3");
    for (int i = 0; i < DIM; i++)
      check(res_word(i) == 15'd5, "R3", $sformatf("wrap result %0d", i), res_word(i), 5);
  endtask

  task automatic t_example;
    int a[DIM*DIM] = '{82,10,16,15,66, 91,28,98,43,4, 13,55,96,92,85,
                       92,96,49,80,94, 64,97,81,96,68};
    int b[DIM] = '{76,75,40,66,18};
    int c[DIM] = '{9800,15846,16555,23124,22939};
    logic [MW-1:0] m;
    logic [VW-1:0] v;
    for (int k = 0; k < DIM * DIM; k++) m[k*W +: W] = W'(a[k]);
    for (int k = 0; k < DIM; k++) v[k*W +: W] = W'(b[k]);
    // follows the wrap run: a stale sum would show here (R4)
    run_core(m, v, 1'b0, "R2");
    for (int i = 0; i < DIM; i++)
      check(res_word(i) == W'(c[i]), "R2", $sformatf("example result %0d", i),
            res_word(i), c[i]);
  endtask

  task automatic t_row_clear;
    logic [MW-1:0] m = '0;
    logic [VW-1:0] v;
    for (int k = 0; k < DIM; k++) v[k*W +: W] = 15'd1;
    for (int j = 0; j < DIM; j++) m[j*W +: W] = 15'h7fff;
    for (int j = 0; j < DIM; j++) m[(2*DIM+j)*W +: W] = W'(j + 1);
    run_core(m, v, 1'b0, "R4");
    check(res_word(0) == 15'd32763, "R4", "saturated row", res_word(0), 32763);
    check(res_word(1) == 15'd0, "R4", "zero row after full row", res_word(1), 0);
    check(res_word(2) == 15'd15, "R4", "row after zero row", res_word(2), 15);
  endtask

  task automatic t_busy_start;
    logic [MW-1:0] m;
    logic [VW-1:0] v;
    for (int k = 0; k < DIM * DIM; k++) m[k*W +: W] = W'(k * 1117 + 3);
    for (int k = 0; k < DIM; k++) v[k*W +: W] = W'(k * 7919 + 11);
    run_core(m, v, 1'b1, "R6");
  endtask

  task automatic t_hold;
    logic [VW-1:0] saved = res_o;
    int moved = 0, strobes = 0;
    for (int n = 0; n < 12; n++) begin
      mat_i = {MW{1'b0}} | MW'(n * 977);
      vec_i = ~vec_i;
      @(posedge clk);
      @(negedge clk);
      if (res_o != saved) moved++;
      if (res_vld_o != '0) strobes++;
    end
    check(moved == 0, "R9", "results moved while idle", moved, 0);
    check(strobes == 0, "R9", "strobes while idle", strobes, 0);
    check(idle_o == 1'b1, "R9", "idle held", idle_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_wrap();
    t_example();
    t_row_clear();
    t_busy_start();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule